// File: doc/BRIEF.md
# Partially Triplicated Reduced-Precision Adder

This block adds two unsigned operands and returns a sum one bit wider than they are. It is hardened where hardening pays most. The operand word is cut at a parameterised split point. The upper, significant slice is built as three separate adder copies, and each result bit of those copies is resolved by a three-input majority function. The lower, less-significant slice is built once and is not protected. Its carry-out feeds all three upper copies as their common carry-in. Its sum bits pass straight into the low end of the result, below the voted upper bits.

The block is purely combinational. For fault-campaign work it has stuck-at injection controls on three kinds of node. Each upper copy has a per-bit force mask and one forced value. The shared carry has an enable and a value. The lower sum has a per-bit mask and one value. With every control low, the block is a plain adder. Any fault confined to one upper copy is hidden. A fault on the shared carry or on a lower sum bit reaches the result, which is the accepted cost of leaving that slice single.

Top module: `ptra_adder`

## Requirements
- R1: With every fault control low (all masks zero, the carry force enable 0), `sum_o` equals the 33-bit value `a_i + b_i`.
- R2: Bit 32 of `sum_o` is the carry-out of the whole addition. For example, 0xFFFFFFFF + 0xFFFFFFFF gives 0x1FFFFFFFE, with bit 32 set.
- R3: Any stuck-at fault confined to a single upper copy is masked, and `sum_o` still equals `a_i + b_i`. Copy k owns bits [k*25 +: 25] of `up_frc_mask_i`. Bit j of that field forces result bit j+8 of that copy, with bit 24 of the field being the copy's carry-out. The forced value is `up_frc_val_i[k]`.
- R4: With `cy_frc_en_i` high, the value `cy_frc_val_i` replaces the lower slice's carry in all three upper copies. `sum_o[32:8]` then equals `a_i[31:8] + b_i[31:8] + cy_frc_val_i`, and `sum_o[7:0]` stays `a_i[7:0] + b_i[7:0]` modulo 256.
- R5: Lower sum bits are not voted. Each bit j set in `lo_frc_mask_i` makes `sum_o[j]` equal `lo_frc_val_i`. All other bits of `sum_o` keep their fault-free values, because the lower carry is taken before the force.
- R6: When two upper copies force the same bits to the same value, the majority vote passes that value: those bits of `sum_o` take the forced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| up_frc_mask_i | input | 75 | Per-copy force masks for the upper results, 25 bits per copy |
| up_frc_val_i | input | 3 | Forced value, one bit per upper copy |
| cy_frc_en_i | input | 1 | Enables the override of the shared carry |
| cy_frc_val_i | input | 1 | Value used for the shared carry when it is overridden |
| lo_frc_mask_i | input | 8 | Force mask on the lower sum bits |
| lo_frc_val_i | input | 1 | Forced value for the masked lower sum bits |
| sum_o | output | 33 | Final sum |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and `sum_o`. The bench drives the operands and fault controls on the falling clock edge. It compares `sum_o` with its behavioural expectation two nanoseconds later, well before the next rising edge. The expected value is built from integer addition, plus explicit mask arithmetic for forced carries, forced lower bits and double-copy faults. It is never taken from the design.

// File: rtl/ptra_pkg.sv
package ptra_pkg;
  // number of redundant copies of the significant slice
  localparam int unsigned NCOPY = 3;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction
endpackage

// File: rtl/ptra_lsb_slice.sv
module ptra_lsb_slice #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] frc_mask_i,
  input  logic         frc_val_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] raw;

  always_comb begin
    raw    = {1'b0, a_i} + {1'b0, b_i};
    cout_o = raw[W];
    sum_o  = (raw[W-1:0] & ~frc_mask_i) | (frc_mask_i & {W{frc_val_i}});
  end
endmodule

// File: rtl/ptra_msb_copy.sv
module ptra_msb_copy #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [W:0]   frc_mask_i,
  input  logic         frc_val_i,
  output logic [W:0]   res_o
);
  logic [W:0] raw;

  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    res_o = (raw & ~frc_mask_i) | (frc_mask_i & {(W+1){frc_val_i}});
  end
endmodule

// File: rtl/ptra_vote3.sv
module ptra_vote3
  import ptra_pkg::*;
#(
  parameter int unsigned W = 25
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] f_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign f_o[g] = maj3(x_i[g], y_i[g], z_i[g]);
  end
endmodule

// File: rtl/ptra_adder.sv
module ptra_adder
  import ptra_pkg::*;
#(
  parameter int unsigned ADD_W = 32,
  parameter int unsigned LO_W  = 8,
  localparam int unsigned HI_W = ADD_W - LO_W,
  localparam int unsigned RW   = HI_W + 1
) (
  input  logic [ADD_W-1:0]    a_i,
  input  logic [ADD_W-1:0]    b_i,
  input  logic [NCOPY*RW-1:0] up_frc_mask_i,
  input  logic [NCOPY-1:0]    up_frc_val_i,
  input  logic                cy_frc_en_i,
  input  logic                cy_frc_val_i,
  input  logic [LO_W-1:0]     lo_frc_mask_i,
  input  logic                lo_frc_val_i,
  output logic [ADD_W:0]      sum_o
);
  logic [LO_W-1:0] lo_sum;
  logic            lo_cout;
  logic            shared_cy;
  logic [RW-1:0]   copy_res [NCOPY];
  logic [RW-1:0]   voted;

  ptra_lsb_slice #(.W(LO_W)) u_lo (
    .a_i        (a_i[LO_W-1:0]),
    .b_i        (b_i[LO_W-1:0]),
    .frc_mask_i (lo_frc_mask_i),
    .frc_val_i  (lo_frc_val_i),
    .sum_o      (lo_sum),
    .cout_o     (lo_cout)
  );

  assign shared_cy = cy_frc_en_i ? cy_frc_val_i : lo_cout;

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    ptra_msb_copy #(.W(HI_W)) u_hi (
      .a_i        (a_i[ADD_W-1:LO_W]),
      .b_i        (b_i[ADD_W-1:LO_W]),
      .cin_i      (shared_cy),
      .frc_mask_i (up_frc_mask_i[k*RW +: RW]),
      .frc_val_i  (up_frc_val_i[k]),
      .res_o      (copy_res[k])
    );
  end

  ptra_vote3 #(.W(RW)) u_vote (
    .x_i (copy_res[0]),
    .y_i (copy_res[1]),
    .z_i (copy_res[2]),
    .f_o (voted)
  );

  assign sum_o = {voted, lo_sum};
endmodule

// File: rtl/ptra_adder_chk.sv
module ptra_adder_chk
  import ptra_pkg::*;
#(
  parameter int unsigned ADD_W = 32,
  parameter int unsigned LO_W  = 8,
  localparam int unsigned HI_W = ADD_W - LO_W,
  localparam int unsigned RW   = HI_W + 1
) (
  input logic [ADD_W-1:0]    a_i,
  input logic [ADD_W-1:0]    b_i,
  input logic [NCOPY*RW-1:0] up_frc_mask_i,
  input logic [NCOPY-1:0]    up_frc_val_i,
  input logic                cy_frc_en_i,
  input logic                cy_frc_val_i,
  input logic [LO_W-1:0]     lo_frc_mask_i,
  input logic                lo_frc_val_i,
  input logic [ADD_W:0]      sum_o
);
  logic [ADD_W:0]   exact;
  logic [HI_W:0]    hi_cy;
  logic [LO_W-1:0]  lo_exp;
  logic [NCOPY-1:0] copy_hit;
  logic             side_clean;

  always_comb begin
    exact = {1'b0, a_i} + {1'b0, b_i};
    hi_cy = {1'b0, a_i[ADD_W-1:LO_W]} + {1'b0, b_i[ADD_W-1:LO_W]}
          + {{HI_W{1'b0}}, cy_frc_val_i};
    lo_exp = (exact[LO_W-1:0] & ~lo_frc_mask_i) | (lo_frc_mask_i & {LO_W{lo_frc_val_i}});
    for (int k = 0; k < NCOPY; k++) copy_hit[k] = |up_frc_mask_i[k*RW +: RW];
    side_clean = !cy_frc_en_i && (lo_frc_mask_i == '0);

    if (side_clean && copy_hit == '0)
      AST_CLEAN_SUM: assert (sum_o == exact);                                  // R1
    if (side_clean && $countones(copy_hit) == 1)
      AST_SINGLE_COPY_MASKED: assert (sum_o == exact);                         // R3
    if (cy_frc_en_i && copy_hit == '0 && lo_frc_mask_i == '0)
      AST_SHARED_CARRY_FORCED: assert (sum_o == {hi_cy, exact[LO_W-1:0]});     // R4
    if (!cy_frc_en_i && copy_hit == '0)
      AST_LOWER_UNVOTED: assert (sum_o == {exact[ADD_W:LO_W], lo_exp});        // R5
  end
endmodule

bind ptra_adder ptra_adder_chk #(.ADD_W(ADD_W), .LO_W(LO_W)) u_chk (.*);

// File: tb/ptra_adder_tb_top.sv
`timescale 1ns/1ps
module ptra_adder_tb_top;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [74:0] up_mask;
  logic [2:0]  up_val;
  logic        cy_en, cy_val;
  logic [7:0]  lo_mask;
  logic        lo_val;
  logic [32:0] sum;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #5 clk = ~clk;

  ptra_adder dut_i (
    .a_i(a), .b_i(b), .up_frc_mask_i(up_mask), .up_frc_val_i(up_val),
    .cy_frc_en_i(cy_en), .cy_frc_val_i(cy_val),
    .lo_frc_mask_i(lo_mask), .lo_frc_val_i(lo_val), .sum_o(sum)
  );

  function automatic logic [32:0] ref_add(input logic [31:0] x, input logic [31:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  task automatic clear_faults();
    up_mask = '0; up_val = '0; cy_en = 1'b0; cy_val = 1'b0; lo_mask = '0; lo_val = 1'b0;
  endtask

  task automatic chk(input string req, input logic [32:0] exp);
    n_tests++;
    if (sum !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h)", req, sum, exp, a, b);
    end
  endtask

  // drive on the falling edge, let the combinational path settle, then compare
  task automatic settle();
    #2;
  endtask

  initial begin
    a = '0; b = '0; clear_faults();
    @(negedge clk); settle();
    chk("R1 idle zero", 33'h0);

    // R1: plain addition on random and corner operands
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk); a = $urandom; b = $urandom; settle();
      chk("R1", ref_add(a, b));
    end
    @(negedge clk); a = 32'h0000_00FF; b = 32'h0000_0001; settle();
    chk("R1 low carry ripple", 33'h0000_0100);

    // R2: top bit is the final carry-out
    @(negedge clk); a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; settle();
    chk("R2 max operands", 33'h1_FFFF_FFFE);
    @(negedge clk); a = 32'h8000_0000; b = 32'h8000_0000; settle();
    chk("R2 carry only", 33'h1_0000_0000);

    // R3: any fault inside a single upper copy is masked
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        a = $urandom; b = $urandom; clear_faults();
        up_mask[k*25 +: 25] = ($urandom == 0) ? 25'h1FF_FFFF : 25'($urandom);
        up_val[k] = 1'($urandom);
        settle();
        chk("R3 single copy fault", ref_add(a, b));
      end
      @(negedge clk); a = 32'hFFFF_FFFF; b = 32'h1; clear_faults();
      up_mask[k*25 +: 25] = 25'h1FF_FFFF; up_val[k] = 1'b0; settle();
      chk("R3 full copy stuck-at-0", 33'h1_0000_0000);
    end
    clear_faults();

    // R4: forced shared carry reaches every upper copy
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); a = $urandom; b = $urandom; cy_en = 1'b1; cy_val = 1'($urandom); settle();
      chk("R4 forced carry",
          {{1'b0, a[31:8]} + {1'b0, b[31:8]} + {24'h0, cy_val}, 8'(a[7:0] + b[7:0])});
    end
    @(negedge clk); a = 32'h0; b = 32'h0; cy_en = 1'b1; cy_val = 1'b1; settle();
    chk("R4 stuck-at-1 on zero operands", 33'h0_0000_0100);
    @(negedge clk); a = 32'hFFFF_FF80; b = 32'h0000_0080; cy_val = 1'b0; settle();
    chk("R4 stuck-at-0 drops ripple", 33'h0_FFFF_FF00);
    clear_faults();

    // R5: lower sum bits are forced directly, upper part unaffected
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); a = $urandom; b = $urandom; lo_mask = 8'($urandom); lo_val = 1'($urandom); settle();
      chk("R5 lower force",
          {ref_add(a, b)[32:8], (ref_add(a, b)[7:0] & ~lo_mask) | (lo_val ? lo_mask : 8'h0)});
    end
    clear_faults();

    // R6: two copies agreeing on a forced value win the vote
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      begin
        logic [24:0] m;
        logic        v;
        int          p;
        a = $urandom; b = $urandom; clear_faults();
        m = 25'($urandom); v = 1'($urandom); p = i % 3;
        up_mask[p*25 +: 25] = m; up_val[p] = v;
        up_mask[((p+1)%3)*25 +: 25] = m; up_val[(p+1)%3] = v;
        settle();
        chk("R6 two-copy fault",
            (ref_add(a, b) & ~{m, 8'h0}) | (v ? {m, 8'h0} : 33'h0));
      end
    end
    clear_faults();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired before completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule